// File: doc/BRIEF.md
# Random Word Source Command Controller

This block sits between a host register bus and a raw bit stream from an entropy source. The host drives it through a fixed lifecycle by writing 32-bit command words. The lifecycle holds the block in reset, releases it, enables it, and then wipes and self-tests it. The block reports where it stands through an 8-bit status code. The self-test counts a fixed number of incoming bits and rejects the source if it sees a long run of identical bits, which is the sign of a stuck input.

After a passing self-test and a host acknowledge, the block shifts in one 32-bit word from the bit stream and raises the "word ready" code. It then waits. The host reads the word, writes a read-acknowledge, and then writes enable. Only after that does collection of the next word begin. A command that does not fit the current phase is dropped without any effect.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: Writing 0x00000001 to byte offset 0x0 puts the block in the held phase from any phase. The status register (offset 0x4, code in bits 7:0, upper bits zero) reads 0xAC from the next cycle on. After the reset pin, the status reads 0x00.
- R2: From 0xAC, the commands 0x00000002 (release), 0x80000000 (enable) and 0x80000004 (wipe and self-test) start the self-test, and the status reads 0x00 while the test runs. When TEST_BITS (1024) valid bits have arrived with no run of RUN_LIMIT (32) equal bits, the status becomes 0x57.
- R3: A run of RUN_LIMIT equal consecutive bits during the self-test makes the status 0xFA, and a run one shorter does not. In 0xFA, every command except 0x00000001 is ignored.
- R4: After 0x57, writing 0x80000008 starts collection. The status turns to 0xED only once 32 valid bits have been taken. Bits presented without the valid strobe, and bits that arrive while 0xED is shown, are not taken.
- R5: A read of offset 0x0 returns the collected word while 0xED is shown, with the first bit received in bit 31. At any other time it returns zero. Read data appears in the cycle after the read strobe.
- R6: In 0xED, writing 0x8000000F clears the status to 0x00. A following 0x80000000 starts a new word, which again needs 32 fresh valid bits.
- R7: A command word that is unknown, or not legal in the current phase, leaves the status unchanged. Examples are enable while 0xAC is shown, and enable while 0xED is shown.
- R8: A write to any offset other than 0x0 has no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data (command word) |
| bus_rdata | output | 32 | Registered read data |
| ent_bit | input | 1 | Raw entropy bit |
| ent_valid | input | 1 | Entropy bit strobe |

## Verification
The self-test is tried with three bit streams. A strictly alternating stream must pass. A stream of runs exactly one bit shorter than the limit must also pass, which separates an off-by-one in the run counter from a correct one. A stream whose run hits the limit exactly must fail, and the status is checked just before the failing bit and again after it. Word collection is tried with two different bit patterns, so that a bit-order or shift-direction error shows in the word that is read. Bits presented without the strobe, and extra bits presented while a word is ready, must leave the word unchanged.

// File: rtl/rng_cmd_pkg.sv
package rng_cmd_pkg;
    localparam logic [31:0] CMD_RESET    = 32'h0000_0001;
    localparam logic [31:0] CMD_RELEASE  = 32'h0000_0002;
    localparam logic [31:0] CMD_ENABLE   = 32'h8000_0000;
    localparam logic [31:0] CMD_ZEROIZE  = 32'h8000_0004;
    localparam logic [31:0] CMD_ACK_ZERO = 32'h8000_0008;
    localparam logic [31:0] CMD_ACK_READ = 32'h8000_000F;

    localparam logic [7:0] ST_NONE  = 8'h00;
    localparam logic [7:0] ST_HELD  = 8'hAC;
    localparam logic [7:0] ST_PASS  = 8'h57;
    localparam logic [7:0] ST_FAIL  = 8'hFA;
    localparam logic [7:0] ST_READY = 8'hED;

    typedef enum logic [3:0] {
        PH_IDLE, PH_HELD, PH_RELEASED, PH_ENABLED, PH_TESTING,
        PH_PASSED, PH_FAILED, PH_COLLECT, PH_READY, PH_DRAINED
    } phase_e;

    function automatic logic [7:0] status_of(phase_e p);
        case (p)
            PH_HELD:   return ST_HELD;
            PH_PASSED: return ST_PASS;
            PH_FAILED: return ST_FAIL;
            PH_READY:  return ST_READY;
            default:   return ST_NONE;
        endcase
    endfunction
endpackage

// File: rtl/rng_health.sv
// Startup test: counts TEST_BITS valid bits, fails on a run of RUN_LIMIT equal bits.
module rng_health #(
    parameter int TEST_BITS = 1024,
    parameter int RUN_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic bit_i,
    input  logic valid_i,
    output logic done_o,
    output logic fail_o
);
    localparam int CNT_W = $clog2(TEST_BITS + 1);
    localparam int RUN_W = $clog2(RUN_LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [RUN_W-1:0] run;
        logic             last;
        logic             fail;
    } hs_t;

    hs_t h_d, h_q;

    assign done_o = h_q.fail || (h_q.cnt == CNT_W'(TEST_BITS));
    assign fail_o = h_q.fail;

    always_comb begin
        h_d = h_q;
        if (clear) begin
            h_d = '0;
        end else if (active && valid_i && !done_o) begin
            h_d.cnt  = h_q.cnt + 1'b1;
            h_d.last = bit_i;
            if (h_q.cnt == '0 || bit_i != h_q.last) begin
                h_d.run = RUN_W'(1);
            end else begin
                h_d.run = h_q.run + 1'b1;
            end
            if (h_d.run == RUN_W'(RUN_LIMIT)) begin
                h_d.fail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end
endmodule

// File: rtl/rng_collect.sv
// Shifts in WORD_W valid bits, first bit ends in the MSB, then holds.
module rng_collect #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              active,
    input  logic              bit_i,
    input  logic              valid_i,
    output logic              full_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
    } cs_t;

    cs_t c_d, c_q;

    assign full_o = (c_q.cnt == CNT_W'(WORD_W));
    assign word_o = c_q.sh;

    always_comb begin
        c_d = c_q;
        if (clear) begin
            c_d = '0;
        end else if (active && valid_i && !full_o) begin
            c_d.sh  = {c_q.sh[WORD_W-2:0], bit_i};
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/rng_cmd_ctrl.sv
module rng_cmd_ctrl
    import rng_cmd_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int TEST_BITS = 1024,
    parameter int RUN_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ent_bit,
    input  logic              ent_valid
);
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);

    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t r_d, r_q;

    logic              h_clear, h_done, h_fail;
    logic              c_clear, c_full;
    logic [DATA_W-1:0] c_word;
    logic              cmd_hit;
    logic [7:0]        status_w;

    assign cmd_hit  = bus_wr && (bus_addr == OFF_CTRL);
    assign status_w = status_of(r_q.phase);

    rng_health #(.TEST_BITS(TEST_BITS), .RUN_LIMIT(RUN_LIMIT)) u_health (
        .clk(clk), .rst_n(rst_n), .clear(h_clear),
        .active(r_q.phase == PH_TESTING),
        .bit_i(ent_bit), .valid_i(ent_valid),
        .done_o(h_done), .fail_o(h_fail)
    );

    rng_collect #(.WORD_W(DATA_W)) u_collect (
        .clk(clk), .rst_n(rst_n), .clear(c_clear),
        .active(r_q.phase == PH_COLLECT),
        .bit_i(ent_bit), .valid_i(ent_valid),
        .full_o(c_full), .word_o(c_word)
    );

    always_comb begin
        r_d     = r_q;
        h_clear = 1'b0;
        c_clear = 1'b0;
        if (cmd_hit && bus_wdata == CMD_RESET) begin
            r_d.phase = PH_HELD;
            r_d.word  = '0;
            h_clear   = 1'b1;
            c_clear   = 1'b1;
        end else begin
            case (r_q.phase)
                PH_HELD:
                    if (cmd_hit && bus_wdata == CMD_RELEASE) r_d.phase = PH_RELEASED;
                PH_RELEASED:
                    if (cmd_hit && bus_wdata == CMD_ENABLE) r_d.phase = PH_ENABLED;
                PH_ENABLED:
                    if (cmd_hit && bus_wdata == CMD_ZEROIZE) begin
                        r_d.phase = PH_TESTING;
                        r_d.word  = '0;
                        h_clear   = 1'b1;
                        c_clear   = 1'b1;
                    end
                PH_TESTING:
                    if (h_done) r_d.phase = h_fail ? PH_FAILED : PH_PASSED;
                PH_PASSED:
                    if (cmd_hit && bus_wdata == CMD_ACK_ZERO) begin
                        r_d.phase = PH_COLLECT;
                        c_clear   = 1'b1;
                    end
                PH_COLLECT:
                    if (c_full) begin
                        r_d.phase = PH_READY;
                        r_d.word  = c_word;
                    end
                PH_READY:
                    if (cmd_hit && bus_wdata == CMD_ACK_READ) r_d.phase = PH_DRAINED;
                PH_DRAINED:
                    if (cmd_hit && bus_wdata == CMD_ENABLE) begin
                        r_d.phase = PH_COLLECT;
                        c_clear   = 1'b1;
                    end
                default: ;
            endcase
        end

        if (bus_rd) begin
            if (bus_addr == OFF_CTRL)
                r_d.rdata = (r_q.phase == PH_READY) ? r_q.word : '0;
            else if (bus_addr == OFF_STAT)
                r_d.rdata = {24'h0, status_w};
            else
                r_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase <= PH_IDLE;
            r_q.word  <= '0;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;
endmodule

// File: rtl/rng_cmd_ctrl_chk.sv
module rng_cmd_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        status_w
);
    logic rst_cmd;
    assign rst_cmd = bus_wr && bus_addr == '0 && bus_wdata == 32'h1;

    AST_RESET_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> status_w == 8'hAC); // R1

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w == 8'hFA && !rst_cmd) |=> status_w == 8'hFA); // R3

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w == 8'hED && !bus_wr) |=> status_w == 8'hED); // R4

    AST_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == '0 && status_w != 8'hED) |=> bus_rdata == 32'h0); // R5

    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        status_w inside {8'h00, 8'hAC, 8'h57, 8'hFA, 8'hED}); // R7

    AST_OFFSET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != '0 && status_w == 8'hAC) |=> status_w == 8'hAC); // R8
endmodule

bind rng_cmd_ctrl rng_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status_w(status_w)
);

// File: tb/test_rng_cmd_ctrl.sv
module test_rng_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ent_bit = 1'b0, ent_valid = 1'b0;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rng_cmd_ctrl i_rng_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ent_bit(ent_bit), .ent_valid(ent_valid)
    );

    // {command word, expected status after it}, applied in order from reset
    localparam logic [39:0] VEC [8] = '{
        {32'h0000_0001, 8'hAC},  // R1 reset command
        {32'h8000_000F, 8'hAC},  // R7 read-ack illegal while held
        {32'h8000_0008, 8'hAC},  // R7 wipe-ack illegal
        {32'h8000_0004, 8'hAC},  // R7 wipe illegal while held
        {32'h8000_0000, 8'hAC},  // R7 enable illegal while held
        {32'h1234_5678, 8'hAC},  // R7 unknown word
        {32'h0000_0002, 8'h00},  // R2 release
        {32'h0000_0001, 8'hAC}   // R1 reset again
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_cmd(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
    endtask

    task automatic chk_status(input string tag, input logic [7:0] exp);
        logic [31:0] v;
        repeat (2) @(negedge clk);
        rd_reg(4'h4, v);
        chk(tag, v, {24'h0, exp});
    endtask

    task automatic feed(input logic b);
        @(negedge clk); ent_valid = 1'b1; ent_bit = b;
        @(negedge clk); ent_valid = 1'b0;
    endtask

    task automatic feed_word(input logic [31:0] w, input int n);
        for (int i = 31; i > 31 - n; i--) feed(w[i]);
    endtask

    task automatic start_test();
        wr_cmd(4'h0, 32'h0000_0001);
        wr_cmd(4'h0, 32'h0000_0002);
        wr_cmd(4'h0, 32'h8000_0000);
        wr_cmd(4'h0, 32'h8000_0004);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_status("R1 status after reset pin", 8'h00);

        for (int i = 0; i < 8; i++) begin
            wr_cmd(4'h0, VEC[i][39:8]);
            chk_status("R1/R7 table step", VEC[i][7:0]);
        end

        // R8: writes at other offsets ignored
        wr_cmd(4'h4, 32'h0000_0002);
        wr_cmd(4'h8, 32'h0000_0002);
        chk_status("R8 other offset ignored", 8'hAC);

        // R2: alternating stream passes
        start_test();
        chk_status("R2 status during test", 8'h00);
        for (int i = 0; i < 1024; i++) feed(i[0]);
        chk_status("R2 alternating passes", 8'h57);

        // R3: runs one shorter than the limit still pass
        start_test();
        for (int i = 0; i < 1024; i++) feed(((i / 31) % 2) == 1);
        chk_status("R3 run of 31 passes", 8'h57);

        // R4: collection
        wr_cmd(4'h0, 32'h8000_0008);
        rd_reg(4'h0, v);
        chk("R5 word zero when not ready", v, 32'h0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ent_bit = i[0]; ent_valid = 1'b0;
        end
        feed_word(32'hA5C3_0F96, 31);
        chk_status("R4 31 bits not ready", 8'h00);
        feed(1'b0);
        chk_status("R4 ready after 32 bits", 8'hED);
        rd_reg(4'h0, v);
        chk("R5 first word", v, 32'hA5C3_0F96);
        for (int i = 0; i < 5; i++) feed(1'b1);
        rd_reg(4'h0, v);
        chk("R4 bits ignored while ready", v, 32'hA5C3_0F96);
        wr_cmd(4'h0, 32'h8000_0000);
        chk_status("R7 enable ignored while ready", 8'hED);

        // R6: ack then enable, next word
        wr_cmd(4'h0, 32'h8000_000F);
        chk_status("R6 ack clears ready", 8'h00);
        rd_reg(4'h0, v);
        chk("R5 word zero after ack", v, 32'h0);
        feed(1'b1);
        wr_cmd(4'h0, 32'h8000_0000);
        feed_word(32'h3C5A_E718, 31);
        chk_status("R6 31 fresh bits not ready", 8'h00);
        feed(1'b0);
        chk_status("R6 second word ready", 8'hED);
        rd_reg(4'h0, v);
        chk("R6 second word value", v, 32'h3C5A_E718);

        // R3: run hitting the limit fails exactly
        start_test();
        for (int i = 0; i < 101; i++) feed(i[0]);
        for (int i = 0; i < 31; i++) feed(1'b1);
        chk_status("R3 31 equal bits no fail", 8'h00);
        feed(1'b1);
        chk_status("R3 32 equal bits fail", 8'hFA);
        wr_cmd(4'h0, 32'h0000_0002);
        wr_cmd(4'h0, 32'h8000_0000);
        wr_cmd(4'h0, 32'h8000_0004);
        wr_cmd(4'h0, 32'h8000_0008);
        chk_status("R3 fail sticky", 8'hFA);
        wr_cmd(4'h0, 32'h0000_0001);
        chk_status("R1 reset leaves fail", 8'hAC);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule